// File: doc/BRIEF.md
# Dual-Limit Modulo Timer Channel with Variable-Frequency PWM

This block is one 16-bit timer channel. On each cycle where the count-enable tick is high, the counter moves one step. It counts up toward an upper limit register or down toward a lower limit register. When the count exactly equals the limit for its current direction, the next tick reloads the counter from a load register instead of stepping it. The counting period is therefore set by the distance between the load value and the limit. Every reload raises a compare flag for one clock cycle.

In the alternating output mode (mode code 3'b100), the two limit registers take turns as the target and the output pin toggles on every match. This gives a pulse train whose low time comes from the upper limit register and whose high time comes from the lower limit register. Both times are measured from the load value. This mode always counts up.

Software or a neighbouring controller writes the three registers through separate write strobes. The counter, the compare flag and the output pin are read directly at the ports.

Top module: `dual_limit_timer`

## Requirements
- R1: After reset, the counter is 0x0000, the upper limit register is 0xFFFF, the lower limit register is 0x0000, the load register is 0x0000, and both cmpFlag and pwmOut are low.
- R2: The counter changes only on cycles where tick is high. A non-matching tick adds one when counting up (countDown low) or subtracts one when counting down (countDown high), wrapping modulo 2^16.
- R3: When counting up, the match target is the upper limit register; when counting down, it is the lower limit register. A tick that finds the counter equal to the target loads the counter from the load register. Counting up, the period is (upper - load + 1) ticks.
- R4: Matching uses equality only. If the target is rewritten below an up-counting counter, the counter keeps incrementing through 0xFFFF, wraps to 0x0000, and reloads only when it reaches the new value.
- R5: cmpFlag is high for exactly the one cycle that follows each tick that caused a reload, and is low at all other times.
- R6: With outMode equal to 3'b100, the first interval targets the upper limit with pwmOut low. Each match swaps the target between the upper and lower limits and inverts pwmOut. The high time is therefore (lower - load + 1) ticks and the low time is (upper - load + 1) ticks.
- R7: With outMode equal to 3'b100, countDown has no effect: every non-matching tick increments the counter.
- R8: With any outMode other than 3'b100, pwmOut is low from the next cycle on, and the alternation restarts on the upper limit when the mode is selected again.
- R9: A register write takes effect from the next cycle. A match evaluated on the same cycle as a write uses the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable for this cycle |
| countDown | input | 1 | 1 = count down, 0 = count up (ignored in mode 3'b100) |
| outMode | input | 3 | Output mode; 3'b100 selects alternating-limit PWM |
| upLimWe | input | 1 | Write strobe for the upper limit register |
| upLimData | input | 16 | Upper limit write value |
| dnLimWe | input | 1 | Write strobe for the lower limit register |
| dnLimData | input | 16 | Lower limit write value |
| loadWe | input | 1 | Write strobe for the load register |
| loadData | input | 16 | Load write value |
| count | output | 16 | Current counter value |
| cmpFlag | output | 1 | One-cycle pulse after each reload |
| pwmOut | output | 1 | Output pin, toggled on matches in mode 3'b100 |

## Verification
The hardest situation to reach from the ports is a counter that has already passed its target: it must travel the whole 16-bit range before the next match. The stimulus builds this case directly. It runs the counter up past 15, then lowers the upper limit to 12 and keeps ticking through roughly 65,500 cycles of wrap-around. Random phases keep the limit and load values small and close together, so that matches, mode switches, writes landing on match cycles, and direction flips in PWM mode occur often.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

  // Alternating-limit PWM output mode code
  localparam logic [2:0] MODE_ALT_PWM = 3'b100;

  // Register file indices
  localparam int REG_UP   = 0;
  localparam int REG_DN   = 1;
  localparam int REG_LOAD = 2;
  localparam int NUM_REGS = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic reload;    // load counter from load register
    logic step;      // step counter by one
    logic stepDown;  // direction of the step
  } dpStrobes_t;

endpackage

// File: rtl/dlt_datapath.sv
module dlt_datapath
  import dlt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [NUM_REGS-1:0] regWe,
  input  logic [W-1:0]     regData [NUM_REGS],
  output logic [W-1:0]     count,
  output logic             matchUp,
  output logic             matchDn
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = W'(1);

  logic [W-1:0] regQ [NUM_REGS];
  logic         pastValid;

  // Three write-strobed registers; upper limit resets to full range
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_regs
    localparam logic [W-1:0] RESET_VAL = (i == REG_UP) ? ALL_ONES : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         regQ[i] <= RESET_VAL;
      else if (regWe[i]) regQ[i] <= regData[i];
    end
  end

  // Equality-only comparators against the registered counter
  assign matchUp = (count == regQ[REG_UP]);
  assign matchDn = (count == regQ[REG_DN]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (strobes.reload) count <= regQ[REG_LOAD];
    else if (strobes.step)   count <= strobes.stepDown ? count - ONE : count + ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R3: a reload puts the load register value into the counter
  a_r3_reload_value: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strobes.reload)) |-> (count == $past(regQ[REG_LOAD])));

  // R2: stepping moves the counter by exactly one in the requested direction
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strobes.step) && !$past(strobes.reload)) |->
      (count == ($past(strobes.stepDown) ? W'($past(count) - ONE) : W'($past(count) + ONE))));

endmodule

// File: rtl/dlt_control.sv
module dlt_control
  import dlt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       countDown,
  input  logic [2:0] outMode,
  input  logic       matchUp,
  input  logic       matchDn,
  output dpStrobes_t strobes,
  output logic       cmpFlag,
  output logic       pwmOut
);

  logic altMode;
  logic onPhase;     // in alternating mode: 1 = targeting lower limit
  logic useDnLimit;
  logic match;
  logic pastValid;

  assign altMode    = (outMode == MODE_ALT_PWM);
  assign useDnLimit = altMode ? onPhase : countDown;
  assign match      = useDnLimit ? matchDn : matchUp;

  always_comb begin
    strobes          = '0;
    strobes.reload   = tick && match;
    strobes.step     = tick && !match;
    strobes.stepDown = !altMode && countDown;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpFlag <= 1'b0;
      onPhase <= 1'b0;
      pwmOut  <= 1'b0;
    end else begin
      cmpFlag <= strobes.reload;
      if (!altMode) begin
        onPhase <= 1'b0;
        pwmOut  <= 1'b0;
      end else if (strobes.reload) begin
        onPhase <= !onPhase;
        pwmOut  <= !pwmOut;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R5: the flag only follows a tick
  a_r5_flag_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && cmpFlag) |-> $past(tick));

  // R6: the output pin changes only together with a compare flag
  a_r6_pin_moves_on_match: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(altMode) && (pwmOut != $past(pwmOut))) |-> cmpFlag);

  // R8: outside the alternating mode the pin is low
  a_r8_pin_low_off_mode: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(altMode)) |-> !pwmOut);

endmodule

// File: rtl/dual_limit_timer.sv
module dual_limit_timer
  import dlt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         countDown,
  input  logic [2:0]   outMode,
  input  logic         upLimWe,
  input  logic [W-1:0] upLimData,
  input  logic         dnLimWe,
  input  logic [W-1:0] dnLimData,
  input  logic         loadWe,
  input  logic [W-1:0] loadData,
  output logic [W-1:0] count,
  output logic         cmpFlag,
  output logic         pwmOut
);

  dpStrobes_t          strobes;
  logic                matchUp;
  logic                matchDn;
  logic [NUM_REGS-1:0] regWe;
  logic [W-1:0]        regData [NUM_REGS];
  logic                pastValid;

  always_comb begin
    regWe             = '0;
    regWe[REG_UP]     = upLimWe;
    regWe[REG_DN]     = dnLimWe;
    regWe[REG_LOAD]   = loadWe;
    regData[REG_UP]   = upLimData;
    regData[REG_DN]   = dnLimData;
    regData[REG_LOAD] = loadData;
  end

  dlt_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .countDown (countDown),
    .outMode   (outMode),
    .matchUp   (matchUp),
    .matchDn   (matchDn),
    .strobes   (strobes),
    .cmpFlag   (cmpFlag),
    .pwmOut    (pwmOut)
  );

  dlt_datapath #(.W(W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .regWe   (regWe),
    .regData (regData),
    .count   (count),
    .matchUp (matchUp),
    .matchDn (matchDn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R2: without a tick the counter holds
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(tick)) |-> $stable(count));

  // R7: in alternating mode a non-flagged tick always increments
  a_r7_up_only_alt_mode: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(tick) && ($past(outMode) == MODE_ALT_PWM) && !cmpFlag) |->
      (count == W'($past(count) + W'(1))));

endmodule

// File: tb/test_dual_limit_timer.sv
module test_dual_limit_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        countDown = 1'b0;
  logic [2:0]  outMode = 3'b000;
  logic        upLimWe = 1'b0;
  logic [15:0] upLimData = '0;
  logic        dnLimWe = 1'b0;
  logic [15:0] dnLimData = '0;
  logic        loadWe = 1'b0;
  logic [15:0] loadData = '0;
  logic [15:0] count;
  logic        cmpFlag;
  logic        pwmOut;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [15:0] mCnt, mUp, mDn, mLoad;
  logic        mFlag, mPin, mOn;

  always #5 clk = ~clk;

  dual_limit_timer i_dual_limit_timer (
    .clk(clk), .rstN(rstN), .tick(tick), .countDown(countDown), .outMode(outMode),
    .upLimWe(upLimWe), .upLimData(upLimData), .dnLimWe(dnLimWe), .dnLimData(dnLimData),
    .loadWe(loadWe), .loadData(loadData), .count(count), .cmpFlag(cmpFlag), .pwmOut(pwmOut)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "count", int'(count), int'(mCnt));
    chk(tag, "cmpFlag", int'(cmpFlag), int'(mFlag));
    chk(tag, "pwmOut", int'(pwmOut), int'(mPin));
  endtask

  // next-state of the model from the requirements, using the current inputs
  function automatic void modelStep();
    logic alt;
    logic [15:0] target;
    alt = (outMode == 3'b100);
    target = alt ? (mOn ? mDn : mUp) : (countDown ? mDn : mUp);
    mFlag = 1'b0;
    if (tick) begin
      if (mCnt == target) begin                 // R3 reload, R5 flag
        mCnt = mLoad;
        mFlag = 1'b1;
        if (alt) begin mOn = !mOn; mPin = !mPin; end   // R6
      end else if (!alt && countDown) mCnt = mCnt - 16'd1;  // R2, R7
      else mCnt = mCnt + 16'd1;
    end
    if (!alt) begin mOn = 1'b0; mPin = 1'b0; end          // R8
    if (upLimWe) mUp = upLimData;                          // R9 applied after match
    if (dnLimWe) mDn = dnLimData;
    if (loadWe)  mLoad = loadData;
  endfunction

  // one clock: model update, edge, sample at negedge
  task automatic cycle(input string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    checkAll(tag);
    upLimWe = 1'b0; dnLimWe = 1'b0; loadWe = 1'b0;
  endtask

  task automatic writeRegs(input string tag, input logic [15:0] up, input logic [15:0] dn,
                           input logic [15:0] ld);
    upLimWe = 1'b1; upLimData = up;
    dnLimWe = 1'b1; dnLimData = dn;
    loadWe  = 1'b1; loadData  = ld;
    tick = 1'b0;
    cycle(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mCnt = 0; mUp = 16'hFFFF; mDn = 0; mLoad = 0; mFlag = 0; mPin = 0; mOn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R1: reset upper limit is full range: up counting does not reload early
    tick = 1'b1;
    repeat (5) cycle("R1");
    chk("R1", "count after 5 ticks", int'(count), 5);

    // R3: up counting, load 2, upper 5 -> period 4
    writeRegs("R3", 16'd5, 16'd0, 16'd2);
    tick = 1'b1;
    repeat (14) cycle("R3");

    // R2/R3: down counting to lower limit 3 from load 9
    writeRegs("R3", 16'd5, 16'd3, 16'd9);
    countDown = 1'b1; tick = 1'b1;
    repeat (20) cycle("R3");

    // R2: sparse ticks, mixed direction
    for (int i = 0; i < 40; i++) begin
      tick = 1'($urandom_range(0, 2) == 0);
      countDown = 1'($urandom_range(0, 1));
      cycle("R2");
    end

    // R6/R7: alternating mode, low time upper 4, high time lower 6, load 1, direction held down
    writeRegs("R6", 16'd4, 16'd6, 16'd1);
    outMode = 3'b100; countDown = 1'b1; tick = 1'b1;
    repeat (40) cycle("R7");
    // R8: leave mode, pin drops; re-enter restarts on upper limit
    outMode = 3'b000; countDown = 1'b0;
    repeat (4) cycle("R8");
    chk("R8", "pwmOut off mode", int'(pwmOut), 0);
    outMode = 3'b100;
    repeat (20) cycle("R8");

    // R9: write upper limit on the exact cycle the counter matches it
    outMode = 3'b000; countDown = 1'b0;
    writeRegs("R9", 16'd30, 16'd0, 16'd20);
    tick = 1'b1;
    while (mCnt != 16'd30) cycle("R9");
    upLimWe = 1'b1; upLimData = 16'd25;
    cycle("R9");
    chk("R9", "reload on old limit", int'(count), 20);
    repeat (12) cycle("R9");

    // R4: limit rewritten below the counter -> full wrap before matching
    writeRegs("R4", 16'd40, 16'd0, 16'd10);
    tick = 1'b1;
    while (mCnt != 16'd15) cycle("R4");
    upLimWe = 1'b1; upLimData = 16'd12;
    cycle("R4");
    while (mCnt != 16'hFFFF) cycle("R4");
    cycle("R4");
    chk("R4", "wrap to zero", int'(count), 0);
    while (mCnt != 16'd12) cycle("R4");
    cycle("R4");
    chk("R4", "reload after wrap", int'(count), 10);
    chk("R5", "flag after wrap match", int'(cmpFlag), 1);
    cycle("R5");
    chk("R5", "flag single cycle", int'(cmpFlag), 0);

    // random phase: small close values, mode and direction changes, writes
    writeRegs("R3", 16'd12, 16'd2, 16'd4);
    for (int i = 0; i < 6000; i++) begin
      tick = 1'($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 19) == 0) countDown = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 49) == 0) outMode = ($urandom_range(0, 1) == 0) ? 3'b100 : 3'($urandom_range(0, 3));
      if ($urandom_range(0, 29) == 0) begin
        loadWe = 1'b1; loadData = 16'($urandom_range(4, 8));
      end
      if ($urandom_range(0, 29) == 0) begin
        upLimWe = 1'b1; upLimData = 16'($urandom_range(8, 20));
      end
      if ($urandom_range(0, 29) == 0) begin
        dnLimWe = 1'b1; dnLimData = 16'($urandom_range(0, 4));
      end
      cycle((outMode == 3'b100) ? "R6" : "R9");
    end

    summary();
    $finish;
  end

endmodule